// File: doc/BRIEF.md
# Stepped-Frequency PWM Channel Bank

This block produces four independent pulse-width-modulated outputs from a shared fixed-rate tick. Each channel takes an 8-bit frequency code, an 8-bit duty code, a polarity-invert bit and an enable bit. The tick is expected at 256 × 2048 Hz. Each output period is cut into 256 equal duty slots. The slot length is set by the frequency code, so the output can run anywhere from 0.5 Hz to 2048 Hz.

The frequency code has two fields. The top two bits pick a base step, and each step is four times the size of the one below it. The low six bits give a multiplier. The period is built from a phase accumulator, so frequencies whose period is not a whole number of ticks are still correct on average. The duty code cannot express 0 %; the shortest active time is one slot in 256. Any setting may change while a channel runs. The change takes hold on the next clock, and the period counter is not restarted, so one period may match neither the old nor the new setting.

Each channel also provides a one-cycle period-start strobe, which test logic uses to find period boundaries.

Top module: `stepped_pwm`

## Requirements
- R1: Frequency code bits 7:6 select the step `s` and bits 5:0 hold the count `c`. With `D = (c+1) << (2*s)`, one output period lasts `2^20 / D` tick periods. When that value is not an integer, a period is never shorter than its floor and never longer than its ceiling.
- R2: Each period has 256 slots numbered from 0. When polarity is not inverted, the output is high in slots 0 through the duty code and low in the rest, which gives (duty+1)/256 of the period.
- R3: A duty code of 255 with normal polarity keeps the output high for the whole period.
- R4: When the polarity bit is 1, an enabled channel drives the complement of its normal-polarity waveform.
- R5: Reset and a low enable both drive the output low and keep the period-start strobe low. After enable falls, the output is low from the next clock edge.
- R6: On the first clock edge with enable high after it was low, the slot counter starts at 0. At that edge the period-start strobe pulses and the output enters the active phase, which is high for normal polarity and low for inverted polarity.
- R7: The period-start strobe is high for exactly one clock at the first cycle of every period.
- R8: A change to the duty, polarity or frequency code of a running channel takes effect at the next clock edge and does not move the period boundaries.
- R9: The slot timebase advances only in cycles where tick is high.
- R10: Each channel runs only from its own inputs. Disabling or reconfiguring one channel does not change the waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase tick, one-cycle pulses at 256 × 2048 Hz |
| freqCode | input | 4×8 | Per-channel frequency code: step in [7:6], count in [5:0] |
| dutyCode | input | 4×8 | Per-channel duty code, active slots = code + 1 |
| polInv | input | 4 | Per-channel output inversion |
| enable | input | 4 | Per-channel run enable |
| pwmOut | output | 4 | PWM outputs |
| periodStart | output | 4 | One-cycle pulse at the first cycle of each period |

## Verification
Two conditions are hard to reach from the ports. The first is a setting change partway through a running period, which must not shift the period boundary. The bench reaches it by counting clocks from a period-start strobe and then changing duty and polarity at fixed slot positions inside the period. The output must respond on the next edge, and the following strobe must still arrive exactly one period after the first.

The second is a code whose period is not a whole number of ticks. The bench drives such a code and checks that the measured period lands on the floor or the ceiling of the ideal value. A gated tick pattern, with tick high only every other clock, shows that the timebase counts ticks and not clocks.

// File: rtl/stepped_pwm_pkg.sv
package stepped_pwm_pkg;

  // Strobes from the per-channel control to the per-channel datapath.
  typedef struct packed {
    logic live;     // channel enabled this cycle
    logic restart;  // first enabled cycle: slot counter to zero
    logic advance;  // step to the next duty slot
  } slotCtl_t;

endpackage

// File: rtl/stepped_pwm_ctrl.sv
module stepped_pwm_ctrl
  import stepped_pwm_pkg::*;
#(
  parameter int COUNT_W    = 6,
  parameter int STEP_W     = 2,
  parameter int STEP_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               enable,
  input  logic [STEP_W-1:0]  stepSel,
  input  logic [COUNT_W-1:0] countF,
  output slotCtl_t           ctl
);

  // Largest increment: (2^COUNT_W) << (STEP_SHIFT * max step).
  localparam int MAX_EXP = COUNT_W + STEP_SHIFT * ((1 << STEP_W) - 1);
  localparam int ACC_W   = MAX_EXP + 1;
  localparam logic [ACC_W-1:0] FULL = ACC_W'(1) << MAX_EXP;

  logic             enPrev;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] incr;
  logic [ACC_W-1:0] sum;
  logic             wrap;

  always_comb begin
    incr = (ACC_W'(countF) + ACC_W'(1)) << (STEP_SHIFT * int'(stepSel));
    sum  = acc + incr;
    wrap = (sum >= FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      acc    <= '0;
    end else begin
      enPrev <= enable;
      if (!enable || !enPrev) begin
        acc <= '0;
      end else if (tick) begin
        acc <= wrap ? (sum - FULL) : sum;
      end
    end
  end

  always_comb begin
    ctl.live    = enable;
    ctl.restart = enable && !enPrev;
    ctl.advance = enable && enPrev && tick && wrap;
  end

  AST_ACC_BELOW_FULL: assert property (@(posedge clk) disable iff (!rstN)
    acc < FULL);  // R1

  AST_ACC_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (enable && enPrev && !tick) |=> $stable(acc));  // R9

  AST_ACC_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (acc == '0));  // R5

endmodule

// File: rtl/stepped_pwm_dp.sv
module stepped_pwm_dp
  import stepped_pwm_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotCtl_t          ctl,
  input  logic [DUTY_W-1:0] duty,
  input  logic              polInv,
  output logic              pwmOut,
  output logic              periodStart
);

  localparam logic [DUTY_W-1:0] SLOT_LAST = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] slotCnt;
  logic [DUTY_W-1:0] slotNext;
  logic              activeNext;
  logic              startNext;

  always_comb begin
    if (!ctl.live || ctl.restart) begin
      slotNext = '0;
    end else if (ctl.advance) begin
      slotNext = slotCnt + DUTY_W'(1);
    end else begin
      slotNext = slotCnt;
    end
    activeNext = (slotNext <= duty);
    startNext  = ctl.live && (ctl.restart || (ctl.advance && slotCnt == SLOT_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt     <= '0;
      pwmOut      <= 1'b0;
      periodStart <= 1'b0;
    end else begin
      slotCnt     <= slotNext;
      pwmOut      <= ctl.live && (activeNext ^ polInv);
      periodStart <= startNext;
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);  // R7

  AST_START_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> (slotCnt == '0));  // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.live |=> (!pwmOut && !periodStart));  // R5

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.live && duty == SLOT_LAST && !polInv) |=> pwmOut);  // R3

  AST_SLOT_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.live && !ctl.restart) |=>
      (slotCnt == $past(slotCnt) || slotCnt == $past(slotCnt) + DUTY_W'(1)));  // R8

endmodule

// File: rtl/stepped_pwm.sv
module stepped_pwm
  import stepped_pwm_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int COUNT_W    = 6,
  parameter int STEP_W     = 2,
  parameter int STEP_SHIFT = 2,
  parameter int DUTY_W     = 8,
  localparam int FREQ_W    = STEP_W + COUNT_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  logic [NUM_CH-1:0][FREQ_W-1:0] freqCode,
  input  logic [NUM_CH-1:0][DUTY_W-1:0] dutyCode,
  input  logic [NUM_CH-1:0]             polInv,
  input  logic [NUM_CH-1:0]             enable,
  output logic [NUM_CH-1:0]             pwmOut,
  output logic [NUM_CH-1:0]             periodStart
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    slotCtl_t ctl;

    stepped_pwm_ctrl #(
      .COUNT_W   (COUNT_W),
      .STEP_W    (STEP_W),
      .STEP_SHIFT(STEP_SHIFT)
    ) uCtrl (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tick),
      .enable (enable[ch]),
      .stepSel(freqCode[ch][COUNT_W +: STEP_W]),
      .countF (freqCode[ch][COUNT_W-1:0]),
      .ctl    (ctl)
    );

    stepped_pwm_dp #(
      .DUTY_W(DUTY_W)
    ) uDp (
      .clk        (clk),
      .rstN       (rstN),
      .ctl        (ctl),
      .duty       (dutyCode[ch]),
      .polInv     (polInv[ch]),
      .pwmOut     (pwmOut[ch]),
      .periodStart(periodStart[ch])
    );
  end

endmodule

// File: tb/stepped_pwm_test.sv
module stepped_pwm_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int GUARD      = 40000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                tick = 1'b1;
  logic [NCH-1:0][7:0] freqCode = '0;
  logic [NCH-1:0][7:0] dutyCode = '0;
  logic [NCH-1:0]      polInv = '0;
  logic [NCH-1:0]      enable = '0;
  logic [NCH-1:0]      pwmOut;
  logic [NCH-1:0]      periodStart;

  int checks = 0;
  int fails  = 0;
  bit tickHalf = 1'b0;

  stepped_pwm uut (
    .clk(clk), .rstN(rstN), .tick(tick),
    .freqCode(freqCode), .dutyCode(dutyCode),
    .polInv(polInv), .enable(enable),
    .pwmOut(pwmOut), .periodStart(periodStart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = tickHalf ? ~tick : 1'b1;
  end

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkRange(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // Reprogram a channel and restart it; returns at the negedge before the restart edge.
  task automatic restartCh(int ch, logic [7:0] f, logic [7:0] d, logic p);
    @(negedge clk);
    freqCode[ch] = f;
    dutyCode[ch] = d;
    polInv[ch]   = p;
    enable[ch]   = 1'b0;
    @(negedge clk);
    enable[ch]   = 1'b1;
  endtask

  // High cycles and length of the next full period, between two start strobes.
  task automatic measure(int ch, output int hi, output int per);
    int guard = 0;
    @(negedge clk);
    while (!periodStart[ch] && guard < GUARD) begin
      @(negedge clk);
      guard++;
    end
    hi  = 0;
    per = 0;
    do begin
      if (pwmOut[ch]) hi++;
      per++;
      @(negedge clk);
    end while (!periodStart[ch] && per < GUARD);
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    checkEq("R5", "reset pwmOut", int'(pwmOut), 0);
    checkEq("R5", "reset periodStart", int'(periodStart), 0);
    rstN = 1'b1;
  endtask

  task automatic testDecode();
    int hi, per;
    restartCh(0, 8'hFF, 8'd63, 1'b0);   // D=4096
    measure(0, hi, per);
    checkEq("R1", "period step3 c63", per, 256);
    checkEq("R2", "high step3 c63 duty63", hi, 64);
    restartCh(1, 8'hDF, 8'd127, 1'b0);  // D=2048
    measure(1, hi, per);
    checkEq("R1", "period step3 c31", per, 512);
    checkEq("R2", "high duty127", hi, 256);
    restartCh(2, 8'hBF, 8'd0, 1'b0);    // D=1024
    measure(2, hi, per);
    checkEq("R1", "period step2 c63", per, 1024);
    checkEq("R2", "high duty0 one slot", hi, 4);
    restartCh(3, 8'h7F, 8'd31, 1'b0);   // D=256
    measure(3, hi, per);
    checkEq("R1", "period step1 c63", per, 4096);
    checkEq("R2", "high duty31", hi, 512);
    restartCh(0, 8'h3F, 8'd127, 1'b0);  // D=64
    measure(0, hi, per);
    checkEq("R1", "period step0 c63", per, 16384);
    checkEq("R2", "high step0 duty127", hi, 8192);
    restartCh(1, 8'hC2, 8'd0, 1'b0);    // D=192, 5461.33 ticks
    measure(1, hi, per);
    checkRange("R1", "fractional period", per, 5461, 5462);
  endtask

  task automatic testFullDuty();
    int hi, per;
    restartCh(2, 8'hFF, 8'd255, 1'b0);
    measure(2, hi, per);
    checkEq("R3", "full duty high", hi, 256);
    checkEq("R3", "full duty period", per, 256);
  endtask

  task automatic testPolarity();
    int hi, per;
    restartCh(3, 8'hFF, 8'd63, 1'b1);
    measure(3, hi, per);
    checkEq("R4", "inverted high", hi, 192);
    checkEq("R4", "inverted period", per, 256);
  endtask

  task automatic testEnable();
    restartCh(1, 8'hFF, 8'd10, 1'b0);
    @(negedge clk);
    checkEq("R6", "start strobe on enable", int'(periodStart[1]), 1);
    checkEq("R6", "active high on enable", int'(pwmOut[1]), 1);
    restartCh(1, 8'hFF, 8'd10, 1'b1);
    @(negedge clk);
    checkEq("R6", "start strobe inverted", int'(periodStart[1]), 1);
    checkEq("R6", "active low inverted", int'(pwmOut[1]), 0);
    @(negedge clk);
    checkEq("R7", "strobe one cycle", int'(periodStart[1]), 0);
  endtask

  task automatic testDisable();
    int seen = 0;
    restartCh(1, 8'hFF, 8'd200, 1'b0);
    repeat (5) @(negedge clk);
    checkEq("R5", "high before disable", int'(pwmOut[1]), 1);
    enable[1] = 1'b0;
    @(negedge clk);
    checkEq("R5", "low after disable", int'(pwmOut[1]), 0);
    for (int i = 0; i < 600; i++) begin
      if (pwmOut[1] || periodStart[1]) seen++;
      @(negedge clk);
    end
    checkEq("R5", "disabled activity", seen, 0);
  endtask

  task automatic testMidChange();
    int cnt = 0;
    restartCh(0, 8'hFF, 8'd63, 1'b0);
    @(negedge clk);                 // start strobe cycle, slot 0
    repeat (100) begin @(negedge clk); cnt++; end
    checkEq("R8", "low at slot 100", int'(pwmOut[0]), 0);
    dutyCode[0] = 8'd200;
    @(negedge clk); cnt++;
    checkEq("R8", "duty change immediate", int'(pwmOut[0]), 1);
    repeat (49) begin @(negedge clk); cnt++; end
    polInv[0] = 1'b1;
    @(negedge clk); cnt++;
    checkEq("R8", "polarity change immediate", int'(pwmOut[0]), 0);
    while (!periodStart[0] && cnt < GUARD) begin @(negedge clk); cnt++; end
    checkEq("R8", "period boundary kept", cnt, 256);
  endtask

  task automatic testTick();
    int hi, per;
    tickHalf = 1'b1;
    restartCh(2, 8'hFF, 8'd63, 1'b0);
    measure(2, hi, per);
    checkEq("R9", "period with half-rate tick", per, 512);
    checkRange("R9", "high with half-rate tick", hi, 127, 128);
    tickHalf = 1'b0;
  endtask

  task automatic testIndependent();
    int hi, per;
    restartCh(2, 8'hDF, 8'd127, 1'b0);
    restartCh(3, 8'hFF, 8'd5, 1'b1);
    @(negedge clk);
    enable[3] = 1'b0;
    measure(2, hi, per);
    checkEq("R10", "other channel period", per, 512);
    checkEq("R10", "other channel high", hi, 256);
    checkEq("R10", "disabled neighbour low", int'(pwmOut[3]), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testDecode();
    testFullDuty();
    testPolarity();
    testEnable();
    testDisable();
    testMidChange();
    testTick();
    testIndependent();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule